// File: doc/BRIEF.md
# Flexible Second-Operand Shifter

This combinational unit produces the second source operand of a data-processing operation, together with the carry that the shift or rotate produces. The caller picks one of three forms. The first is an 8-bit constant rotated right by an even amount. The second is a register value shifted by a 5-bit count taken from the instruction. The third is a register value shifted by a count held in another register. Fetch, decode and register reads are done upstream. This block only takes the decoded fields and the register values and returns the operand.

Counts held in a register come from a whole byte, so they can be 32 or larger. Each shift kind has its own defined result and carry for those large counts. A count of zero leaves the value untouched and passes the incoming carry flag straight through.

Top module: `opnd2_shifter`

## Requirements
- R1: With `form_sel` = 00, `opnd_out` is `imm_byte`, zero-extended to 32 bits and rotated right by twice `imm_rot`.
- R2: In the immediate form, `carry_out` is bit 31 of `opnd_out` when `imm_rot` is nonzero, and equals `carry_in` when `imm_rot` is zero.
- R3: `form_sel` = 01 takes the count from `imm_shamt` (5 bits, unsigned). `form_sel` = 10 or 11 takes the count from `rs_val[7:0]` only, and `rs_val[31:8]` has no effect on either output.
- R4: `shift_kind` selects the operation: 00 logical left, 01 logical right, 10 arithmetic right, 11 rotate right. For counts 1 to 31, `carry_out` is the last bit shifted out.
- R5: In either register form, a count of zero gives `opnd_out` = `rm_val` and `carry_out` = `carry_in`, for every shift kind.
- R6: A logical left or logical right shift by exactly 32 gives zero, with `carry_out` equal to `rm_val[0]` for left and `rm_val[31]` for right.
- R7: A logical left or logical right shift by more than 32 gives zero with `carry_out` = 0.
- R8: An arithmetic right shift by 32 or more fills every bit with `rm_val[31]`, and `carry_out` also equals `rm_val[31]`.
- R9: A rotate right by a register count rotates by the count modulo 32. A nonzero count that is a multiple of 32 leaves the value unchanged, with `carry_out` = `rm_val[31]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| form_sel | input | 2 | Operand form: 00 immediate, 01 register by immediate count, 1x register by register count |
| shift_kind | input | 2 | Shift kind for the register forms |
| imm_byte | input | 8 | Constant for the immediate form |
| imm_rot | input | 4 | Rotate field; the rotate amount is twice this value |
| imm_shamt | input | 5 | Shift count for the register-by-immediate form |
| rm_val | input | 32 | Register value to be shifted |
| rs_val | input | 32 | Register holding the count; only the low byte is used |
| carry_in | input | 1 | Current carry flag |
| opnd_out | output | 32 | Formed operand |
| carry_out | output | 1 | Shifter carry |

## Verification
Both outputs are purely combinational. They are valid in the same cycle the inputs change, with no register in the path. The bench therefore drives each vector just after a falling clock edge and compares the outputs 2 ns later, still within the same cycle and well away from any edge. The expected values come from a model that moves the value one bit position per step and records each bit that leaves. The large-count, zero-count and rotate-wrap cases then follow from repetition, without any special rules in the model.

// File: rtl/opnd2_shifter.sv
module opnd2_shifter #(
  parameter int W       = 32,
  parameter int IMM_W   = 8,
  parameter int ROT_W   = 4,
  parameter int SHAMT_W = 5,
  parameter int CNT_W   = 8
) (
  input  logic [1:0]         form_sel,
  input  logic [1:0]         shift_kind,
  input  logic [IMM_W-1:0]   imm_byte,
  input  logic [ROT_W-1:0]   imm_rot,
  input  logic [SHAMT_W-1:0] imm_shamt,
  input  logic [W-1:0]       rm_val,
  input  logic [W-1:0]       rs_val,
  input  logic               carry_in,
  output logic [W-1:0]       opnd_out,
  output logic               carry_out
);
  localparam int LW = $clog2(W);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(W);

  logic [W-1:0]        imm_val, imm_res, ror_res;
  logic [ROT_W:0]      rot2;
  logic [CNT_W-1:0]    amt, asr_amt;
  logic [LW-1:0]       rr;
  logic [W:0]          lsl_w, lsr_w;
  logic signed [W:0]   asr_w;

  assign imm_val = W'(imm_byte);
  assign rot2    = {imm_rot, 1'b0};
  assign imm_res = W'({imm_val, imm_val} >> rot2);

  assign amt     = (form_sel == 2'b01) ? CNT_W'(imm_shamt) : rs_val[CNT_W-1:0];
  assign asr_amt = (amt > FULL) ? FULL : amt;
  assign rr      = amt[LW-1:0];

  assign lsl_w   = {1'b0, rm_val} << amt;
  assign lsr_w   = {rm_val, 1'b0} >> amt;
  assign asr_w   = $signed({rm_val, 1'b0}) >>> asr_amt;
  assign ror_res = W'({rm_val, rm_val} >> rr);

  always_comb begin
    opnd_out  = rm_val;
    carry_out = carry_in;
    if (form_sel == 2'b00) begin
      opnd_out  = imm_res;
      carry_out = (imm_rot == '0) ? carry_in : imm_res[W-1];
    end else if (amt != '0) begin
      case (shift_kind)
        2'b00: {carry_out, opnd_out} = lsl_w;
        2'b01: {opnd_out, carry_out} = lsr_w;
        2'b10: {opnd_out, carry_out} = asr_w;
        default: begin
          opnd_out  = ror_res;
          carry_out = ror_res[W-1];
        end
      endcase
    end
  end
endmodule

// File: rtl/opnd2_shifter_chk.sv
module opnd2_shifter_chk #(
  parameter int W = 32
) (
  input logic [1:0]   form_sel,
  input logic [1:0]   shift_kind,
  input logic [3:0]   imm_rot,
  input logic [4:0]   imm_shamt,
  input logic [W-1:0] rm_val,
  input logic [W-1:0] rs_val,
  input logic         carry_in,
  input logic [W-1:0] opnd_out,
  input logic         carry_out
);
  logic [7:0] cnt;
  assign cnt = (form_sel == 2'b01) ? {3'b000, imm_shamt} : rs_val[7:0];

  always_comb begin
    if (form_sel == 2'b00 && imm_rot == 4'd0)
      p_imm_carry_r2: assert (carry_out == carry_in);
    if (form_sel != 2'b00 && cnt == 8'd0)
      p_zero_count_r5: assert (opnd_out == rm_val && carry_out == carry_in);
    if (form_sel != 2'b00 && !shift_kind[1] && cnt > 8'd32)
      p_long_shift_r7: assert (opnd_out == '0 && !carry_out);
    if (form_sel != 2'b00 && shift_kind == 2'b10 && cnt >= 8'd32)
      p_asr_fill_r8: assert (opnd_out == {W{rm_val[W-1]}} && carry_out == rm_val[W-1]);
    if (form_sel != 2'b00 && shift_kind == 2'b11 && cnt != 8'd0 && cnt[4:0] == 5'd0)
      p_ror_wrap_r9: assert (opnd_out == rm_val && carry_out == rm_val[W-1]);
  end
endmodule

bind opnd2_shifter opnd2_shifter_chk #(.W(W)) u_chk (
  .form_sel(form_sel), .shift_kind(shift_kind), .imm_rot(imm_rot),
  .imm_shamt(imm_shamt), .rm_val(rm_val), .rs_val(rs_val),
  .carry_in(carry_in), .opnd_out(opnd_out), .carry_out(carry_out)
);

// File: tb/opnd2_shifter_test.sv
module opnd2_shifter_test;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic [1:0]  form_sel, shift_kind;
  logic [7:0]  imm_byte;
  logic [3:0]  imm_rot;
  logic [4:0]  imm_shamt;
  logic [31:0] rm_val, rs_val, opnd_out;
  logic        carry_in, carry_out;

  int n_vec = 0, n_bad = 0;

  opnd2_shifter uut (
    .form_sel(form_sel), .shift_kind(shift_kind), .imm_byte(imm_byte),
    .imm_rot(imm_rot), .imm_shamt(imm_shamt), .rm_val(rm_val), .rs_val(rs_val),
    .carry_in(carry_in), .opnd_out(opnd_out), .carry_out(carry_out)
  );

  function automatic logic [32:0] model(input logic [1:0] f, input logic [1:0] k,
      input logic [7:0] ib, input logic [3:0] ir, input logic [4:0] is,
      input logic [31:0] rm, input logic [31:0] rs, input logic cin);
    logic [31:0] v;
    logic c;
    int n;
    c = cin;
    if (f == 2'b00) begin
      v = {24'd0, ib};
      n = 2 * int'(ir);
      for (int i = 0; i < n; i++) v = {v[0], v[31:1]};
      if (n != 0) c = v[31];
    end else begin
      v = rm;
      n = (f == 2'b01) ? int'(is) : int'(rs[7:0]);
      for (int i = 0; i < n; i++) begin
        case (k)
          2'b00: begin c = v[31]; v = {v[30:0], 1'b0}; end
          2'b01: begin c = v[0];  v = {1'b0, v[31:1]}; end
          2'b10: begin c = v[0];  v = {v[31], v[31:1]}; end
          default: begin c = v[0]; v = {v[0], v[31:1]}; end
        endcase
      end
    end
    return {c, v};
  endfunction

  function automatic string tag_of(input logic [1:0] f, input logic [1:0] k,
      input logic [3:0] ir, input logic [4:0] is, input logic [31:0] rs);
    int n;
    if (f == 2'b00) return (ir == 0) ? "R2" : "R1";
    n = (f == 2'b01) ? int'(is) : int'(rs[7:0]);
    if (n == 0) return "R5";
    if (k == 2'b11 && n >= 32) return "R9";
    if (k == 2'b10 && n >= 32) return "R8";
    if (n == 32) return "R6";
    if (n > 32) return "R7";
    return (f == 2'b01) ? "R4" : "R3";
  endfunction

  task automatic apply(input logic [1:0] f, input logic [1:0] k, input logic [7:0] ib,
      input logic [3:0] ir, input logic [4:0] is, input logic [31:0] rm,
      input logic [31:0] rs, input logic cin, input string tg);
    logic [32:0] exp;
    @(negedge clk);
    form_sel = f; shift_kind = k; imm_byte = ib; imm_rot = ir;
    imm_shamt = is; rm_val = rm; rs_val = rs; carry_in = cin;
    #2;
    exp = model(f, k, ib, ir, is, rm, rs, cin);
    n_vec++;
    if ({carry_out, opnd_out} !== exp) begin
      n_bad++;
      $display("FAIL %s: form=%b kind=%b got c=%b v=%h exp c=%b v=%h",
               tg, f, k, carry_out, opnd_out, exp[32], exp[31:0]);
    end
  endtask

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    // R1 R2: immediate rotations
    apply(2'b00, 2'b00, 8'hFF, 4'd0, 5'd0, 0, 0, 1'b1, "R2");
    apply(2'b00, 2'b00, 8'h81, 4'd1, 5'd0, 0, 0, 1'b0, "R1");
    apply(2'b00, 2'b00, 8'h3F, 4'd4, 5'd0, 0, 0, 1'b1, "R2");
    apply(2'b00, 2'b00, 8'h02, 4'd15, 5'd0, 0, 0, 1'b1, "R1");
    // R5: zero count, each kind, both register forms
    for (int k = 0; k < 4; k++) begin
      apply(2'b01, 2'(k), 0, 0, 5'd0, 32'hDEADBEEF, 0, 1'b1, "R5");
      apply(2'b10, 2'(k), 0, 0, 5'd0, 32'h80000001, 32'hFFFFFF00, 1'b0, "R5");
    end
    // R4: ordinary counts
    apply(2'b01, 2'b00, 0, 0, 5'd1, 32'h80000000, 0, 1'b0, "R4");
    apply(2'b01, 2'b01, 0, 0, 5'd31, 32'h80000000, 0, 1'b0, "R4");
    apply(2'b01, 2'b10, 0, 0, 5'd4, 32'h8000000F, 0, 1'b0, "R4");
    apply(2'b01, 2'b11, 0, 0, 5'd8, 32'h12345678, 0, 1'b0, "R4");
    // R3: upper count bits ignored
    apply(2'b10, 2'b00, 0, 0, 0, 32'h0000FFFF, 32'hABCDEF04, 1'b0, "R3");
    apply(2'b11, 2'b01, 0, 0, 0, 32'hF0000000, 32'h00000110, 1'b0, "R3");
    // R6, R7
    apply(2'b10, 2'b00, 0, 0, 0, 32'h00000001, 32'd32, 1'b0, "R6");
    apply(2'b10, 2'b01, 0, 0, 0, 32'h80000000, 32'd32, 1'b0, "R6");
    apply(2'b10, 2'b00, 0, 0, 0, 32'hFFFFFFFF, 32'd33, 1'b1, "R7");
    apply(2'b10, 2'b01, 0, 0, 0, 32'hFFFFFFFF, 32'd255, 1'b1, "R7");
    // R8
    apply(2'b10, 2'b10, 0, 0, 0, 32'h80000000, 32'd32, 1'b0, "R8");
    apply(2'b10, 2'b10, 0, 0, 0, 32'h7FFFFFFF, 32'd200, 1'b1, "R8");
    // R9
    apply(2'b10, 2'b11, 0, 0, 0, 32'h80000001, 32'd32, 1'b0, "R9");
    apply(2'b10, 2'b11, 0, 0, 0, 32'h00000001, 32'd64, 1'b1, "R9");
    apply(2'b10, 2'b11, 0, 0, 0, 32'h00000003, 32'd33, 1'b0, "R9");
    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic [1:0] f, k;
      logic [31:0] rs;
      logic [3:0] ir;
      logic [4:0] is;
      f = 2'($urandom); k = 2'($urandom);
      ir = 4'($urandom); is = 5'($urandom);
      rs = $urandom;
      if (($urandom & 3) == 0) rs[7:0] = 8'(32 * ($urandom % 8));
      apply(f, k, 8'($urandom), ir, is, $urandom, rs, 1'($urandom),
            tag_of(f, k, ir, is, rs));
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule